// File: doc/BRIEF.md
# Edge-Capturing General-Purpose I/O Port

This block is a small general-purpose I/O peripheral placed on a memory-mapped slave bus. Software sees four word-spaced registers: the output data latch, a per-pin direction word, an interrupt enable word and a sticky record of rising edges seen on the pins. Each pin can be an output, driven from the data latch with its output enable asserted, or an input, sampled through a synchronizer.

Input pins are first passed through a chain of flip-flops so that an unrelated external signal can be read safely. Once synchronized, each pin is compared with its value one cycle earlier. A 0-to-1 change sets the matching bit of the edge record. That bit stays set until software writes a 1 to it. The interrupt line is a level: it is high while any recorded edge has its enable bit set. Reads are combinational and complete in the same cycle as the read strobe. Writes take effect at the next clock edge.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the data, direction, interrupt enable and edge record registers are all 0. `pin_oe`, `pin_out` and `irq` are 0, so every pin starts as an input.
- R2: Byte address bits [3:2] select the register: 0 data, 1 direction, 2 interrupt enable, 3 edge record. Address bits [1:0] are ignored. A write stores `wdata[7:0]` into the selected register at the next clock edge.
- R3: For each pin, a direction bit of 1 drives `pin_oe` high and drives `pin_out` with the data register bit. A direction bit of 0 drives both `pin_oe` and `pin_out` low for that pin.
- R4: A read of the data word returns the data register bit for output pins and the synchronized pin for input pins. `rdata[31:8]` is 0 on every read, and `rdata` is 0 while `rd` is low.
- R5: An input change set up before clock edge k is not visible in a data read after edge k. It becomes visible after edge k+1 (two synchronizer flops).
- R6: An edge record bit is set after edge k+2 when its pin rose before edge k. A falling edge or a pin held high sets no bit.
- R7: An edge record bit stays set until a write to word 3 has a 1 in that position. Bits written as 0 are kept. If a rise and a clear hit the same bit at the same edge, the bit ends up set.
- R8: `irq` is high exactly when some bit is set in both the edge record and the interrupt enable register.
- R9: Reads of words 1, 2 and 3 return the direction, interrupt enable and edge record registers in bits [7:0]. A read changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Byte address of the register |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Output drive values |
| pin_oe | output | 8 | Per-pin output enable |
| irq | output | 1 | Level interrupt |

## Verification
All stimulus is applied at the falling clock edge, so a value applied there is in place before the next rising edge k. Register writes, pin drive and output enables are checked after edge k. Reads are sampled in the same low phase as the strobe. Each pin change is followed edge by edge: the data read is checked to still show the old value after edge k and the new value after edge k+1. The edge record and `irq` are checked to be clear after edge k+1 and set after edge k+2. The clear-versus-rise collision is arranged so that the clear write lands on edge k+2.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    // Word select taken from byte address bits [3:2]
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_CAP  = 2'd3
    } reg_sel_e;

    localparam int SEL_LSB = 2;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q[STAGES-1];

    AST_SYNC_FIRST_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q[0] == $past(din)));  // R5

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage_chk
            AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (st_q[g] == $past(st_q[g-1])));  // R5
        end
    endgenerate

endmodule

// File: rtl/rise_capture.sv
module rise_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] cap_o
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] cap;
    } cap_state_t;

    cap_state_t s_d, s_q;
    logic [W-1:0] rise;

    always_comb begin
        rise       = lvl_i & ~s_q.prev;
        s_d.prev   = lvl_i;
        // a new rise outranks a same-cycle clear
        s_d.cap    = (s_q.cap & ~clr_i) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cap_o = s_q.cap;

    AST_CAP_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(rise) & ~cap_o) == '0));  // R6

    AST_CAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(cap_o) & ~$past(clr_i)) & ~cap_o) == '0));  // R7

    AST_CAP_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((cap_o & ~$past(cap_o)) & ~$past(lvl_i)) == '0));  // R6

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
    parameter int PORT_W = 8,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 4,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic              irq
);
    import gpio_edge_pkg::*;

    localparam int PAD_W = BUS_W - PORT_W;

    typedef struct packed {
        logic [PORT_W-1:0] data;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] mask;
    } ctl_state_t;

    ctl_state_t c_d, c_q;
    reg_sel_e   sel;
    logic [PORT_W-1:0] pin_sync_v;
    logic [PORT_W-1:0] cap_v;
    logic [PORT_W-1:0] cap_clr;
    logic [PORT_W-1:0] rd_word;
    logic              unused_bits;

    assign sel         = reg_sel_e'(addr[SEL_LSB +: 2]);
    assign unused_bits = ^{wdata[BUS_W-1:PORT_W], addr[ADDR_W-1:SEL_LSB+2], addr[SEL_LSB-1:0]};

    pin_sync #(.W(PORT_W), .STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pin_sync_v)
    );

    rise_capture #(.W(PORT_W)) u_cap (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl_i(pin_sync_v),
        .clr_i(cap_clr),
        .cap_o(cap_v)
    );

    always_comb begin
        c_d     = c_q;
        cap_clr = '0;
        if (wr) begin
            case (sel)
                SEL_DATA: c_d.data = wdata[PORT_W-1:0];
                SEL_DIR:  c_d.dir  = wdata[PORT_W-1:0];
                SEL_MASK: c_d.mask = wdata[PORT_W-1:0];
                SEL_CAP:  cap_clr  = wdata[PORT_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_DATA: rd_word = (c_q.dir & c_q.data) | (~c_q.dir & pin_sync_v);
            SEL_DIR:  rd_word = c_q.dir;
            SEL_MASK: rd_word = c_q.mask;
            SEL_CAP:  rd_word = cap_v;
            default:  rd_word = '0;
        endcase
        rdata = rd ? {{PAD_W{1'b0}}, rd_word} : '0;
    end

    assign pin_oe  = c_q.dir;
    assign pin_out = c_q.dir & c_q.data;
    assign irq     = |(cap_v & c_q.mask);

    AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_DATA) |=> (c_q.data == $past(wdata[PORT_W-1:0])));  // R2

    AST_OE_AFTER_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_DIR) |=> (pin_oe == $past(wdata[PORT_W-1:0])));  // R3

    AST_NO_DRIVE_ON_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0));  // R3

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (c_q.mask != '0));  // R8

    AST_READ_NO_SIDE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr) |=> $stable(c_q));  // R9

endmodule

// File: tb/tb_gpio_edge_port.sv
module tb_gpio_edge_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gpio_edge_port dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all bus tasks start and end at a falling edge
    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        addr = a; rd = 1'b1;
        #2;
        d = rdata;
        rd = 1'b0;
        #1;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 oe", {24'd0, pin_oe}, 32'h0);
        chk("R1 out", {24'd0, pin_out}, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);
        bus_rd(4'h4, v); chk("R1 dir", v, 32'h0);
        bus_rd(4'h8, v); chk("R1 mask", v, 32'h0);
        bus_rd(4'hC, v); chk("R1 cap", v, 32'h0);
        chk("R4 idle rdata", rdata, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        bus_wr(4'h5, 32'hFFFF_FF3C);   // low address bits ignored, word 1
        bus_rd(4'h6, v); chk("R2 dir offset", v, 32'h0000_003C);
        bus_wr(4'hB, 32'h1234_56A5);
        bus_rd(4'h8, v); chk("R9 mask read", v, 32'h0000_00A5);
        bus_rd(4'h4, v); chk("R2 dir kept", v, 32'h0000_003C);
        bus_wr(4'h8, 32'h0);
    endtask

    task automatic t_drive();
        logic [31:0] v;
        pin_in = 8'h00;
        bus_wr(4'h0, 32'hAB00_00F0);
        bus_wr(4'h4, 32'h0000_00CC);
        chk("R3 oe", {24'd0, pin_oe}, 32'h0000_00CC);
        chk("R3 out", {24'd0, pin_out}, 32'h0000_00C0);
        pin_in = 8'h33;
        cycles(3);
        bus_rd(4'h0, v); chk("R4 mixed read", v, 32'h0000_00F3);
        bus_wr(4'h4, 32'h0);
        chk("R3 out off", {24'd0, pin_out}, 32'h0);
        pin_in = 8'h00;
        cycles(4);
        bus_wr(4'hC, 32'hFF);
    endtask

    task automatic t_sync_and_capture();
        logic [31:0] v;
        bus_wr(4'h8, 32'h01);
        pin_in = 8'h01;
        @(posedge clk); @(negedge clk);            // edge k
        bus_rd(4'h0, v); chk("R5 not yet visible", v, 32'h0);
        @(posedge clk); @(negedge clk);            // edge k+1
        bus_rd(4'h0, v); chk("R5 visible", v, 32'h01);
        bus_rd(4'hC, v); chk("R6 cap not yet", v, 32'h0);
        chk("R8 irq low early", {31'd0, irq}, 32'h0);
        @(posedge clk); @(negedge clk);            // edge k+2
        bus_rd(4'hC, v); chk("R6 cap set", v, 32'h01);
        chk("R8 irq high", {31'd0, irq}, 32'h1);
        cycles(3);
        bus_rd(4'hC, v); chk("R6 held high no new bit", v, 32'h01);
        bus_rd(4'hC, v); chk("R9 read no clear", v, 32'h01);
    endtask

    task automatic t_clear_and_fall();
        logic [31:0] v;
        pin_in = 8'h07;
        cycles(4);
        bus_rd(4'hC, v); chk("R6 more rises", v, 32'h07);
        bus_wr(4'hC, 32'h0000_0002);
        bus_rd(4'hC, v); chk("R7 partial clear", v, 32'h05);
        pin_in = 8'h00;
        cycles(4);
        bus_rd(4'hC, v); chk("R6 fall ignored", v, 32'h05);
        bus_wr(4'h8, 32'h02);
        chk("R8 irq masked", {31'd0, irq}, 32'h0);
        bus_wr(4'h8, 32'h04);
        chk("R8 irq other bit", {31'd0, irq}, 32'h1);
        bus_wr(4'hC, 32'hFF);
        bus_rd(4'hC, v); chk("R7 full clear", v, 32'h0);
        chk("R8 irq cleared", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        pin_in = 8'h80;
        @(posedge clk); @(negedge clk);            // edge k
        @(posedge clk); @(negedge clk);            // edge k+1
        bus_wr(4'hC, 32'h80);                      // clear lands on edge k+2
        bus_rd(4'hC, v); chk("R7 rise beats clear", v, 32'h80);
        bus_wr(4'hC, 32'h80);
        bus_rd(4'hC, v); chk("R7 later clear", v, 32'h0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_drive();
        t_sync_and_capture();
        t_clear_and_fall();
        t_set_wins();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule